// File: doc/BRIEF.md
# Two-Pin Compare-Match Timer with Pad Multiplexer

This block is one timer channel. It has a 16-bit up-counter, two compare registers and two output pins. The pin tied to compare register A is called pin A, and the pin tied to compare register B is called pin B.

The channel has two modes:
- **Normal mode.** Each pin moves to its own programmed level when the counter equals that pin's compare value. The counter runs freely and wraps from its maximum value to zero.
- **Pulse-width mode.** Register A sets the period: a match on A clears the counter and returns pin B to its initial level. Register B sets the duty: a match on B drives pin B to its match level.

Each pin has two further controls:
- **Pin-control write.** Writing a pin-control field loads that pin's level at once. The one exception is pin A in pulse-width mode, which keeps its level.
- **Pad source.** A per-pin function-select bit routes either the timer level or a port level to the pad. In port mode the pad is driven only when software enables it, and stays high-impedance otherwise.

The intended use is fault recovery without a reset. After a fault, software switches a pad to port mode and forces a safe level there. It then stops the channel, changes mode, re-initializes the pins, hands the pads back to the timer and restarts.

The channel has a two-state controller:
- `ST_HALT` moves to `ST_COUNT` when the control register is written with bit0 set.
- `ST_COUNT` moves to `ST_HALT` when the control register is written with bit0 clear.
- Any other cycle keeps the current state.

Top module: `cmt_pin_timer`

## Requirements
- R1: During and just after reset, both timer levels are 0, both pads have output enable 0, the counter is 0 and the controller is in `ST_HALT`.
- R2: Writes use one strobe cycle, with the address on `wr_addr` and data on `wr_data`. The address map is:
  - 0: control. Bit0 is the start bit; bit1 selects pulse-width mode when set.
  - 1: pin A control. Bit0 is the initial level; bit1 is the match level.
  - 2: pin B control, with the same layout as address 1.
  - 3: function select. Bit n set gives pin n to the timer.
  - 4: port. Bits 1:0 are the port levels; bits 3:2 are the pad drive enables.
  - 5: compare A.
  - 6: compare B.
  - 7: counter.
- R3: A pin-control write sets that pin's timer level to the written initial level on the following cycle. This applies to pin B in both modes and to pin A in normal mode, and it takes priority over a compare match in the same cycle.
- R4: In pulse-width mode, a write to pin A control stores the new fields but leaves pin A's level unchanged.
- R5: The counter advances only in `ST_COUNT`. In `ST_HALT`, the counter and both timer levels hold, except when a register is written.
- R6: In normal mode, in a running cycle where the counter equals compare A (or B), pin A (or B) takes its match level on the next cycle. The counter steps from 0xFFFF to 0.
- R7: In pulse-width mode, in a running cycle where the counter equals compare A, the counter becomes 0 and pin B returns to its initial level. A running cycle with the counter equal to compare B drives pin B to its match level. When A and B match together, the period action wins. Matches never change pin A in this mode.
- R8: When a pin's function-select bit is 1, its pad is driven with its timer level. When it is 0, the pad drives the port level, with output enable equal to that pin's port drive-enable bit.
- R9: A counter write loads the written value on the next cycle and overrides counting and period clearing in that cycle.
- R10: A channel stopped in pulse-width mode, switched to normal mode, re-initialized and restarted runs with normal-mode behaviour from the loaded counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pad_out | output | 2 | Pad level, bit0 pin A, bit1 pin B |
| pad_oe | output | 2 | Pad drive enable (0 = high-impedance) |
| tmr_lvl | output | 2 | Timer output levels before the pad multiplexer |
| cnt_val | output | 16 | Current counter value |

## Verification
The bench sweeps both modes over grids of small compare values.

In pulse-width mode the grid includes a duty value of zero, a duty value equal to the period value, and a duty value past the period. These cases catch a design that lets the duty match override the period clear, or that clears the counter one cycle late (which stretches the period by one count).

Other targeted cases:
- A counter load near 0xFFFF catches a missing wrap.
- A counter write made in the same cycle as a period match catches the wrong precedence between the two.
- A pin-A control write in pulse-width mode catches a design that re-initializes the period pin.
- The fault-recovery sequence checks that the pads really go high-impedance or to the forced port level, and that after the mode change no period clearing remains.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } chan_state_e;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NPIN   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG_A = 3'd1;
    localparam logic [ADDR_W-1:0] A_CFG_B = 3'd2;
    localparam logic [ADDR_W-1:0] A_FSEL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PORT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP_A = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMP_B = 3'd6;
    localparam logic [ADDR_W-1:0] A_CNT   = 3'd7;
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= clr ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_init,
    input  logic cfg_match,
    input  logic cfg_keep,
    input  logic hit_init,
    input  logic hit_match,
    output logic lvl
);
    logic init_q;
    logic match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q  <= 1'b0;
            match_q <= 1'b0;
        end else if (cfg_wr) begin
            init_q  <= cfg_init;
            match_q <= cfg_match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl <= 1'b0;
        end else if (cfg_wr && !cfg_keep) begin
            lvl <= cfg_init;
        end else if (hit_init) begin
            lvl <= init_q;
        end else if (hit_match) begin
            lvl <= match_q;
        end
    end
endmodule

// File: rtl/cmt_padmux.sv
module cmt_padmux #(
    parameter int unsigned NP = 2
) (
    input  logic [NP-1:0] fsel,
    input  logic [NP-1:0] tmr_lvl,
    input  logic [NP-1:0] port_lvl,
    input  logic [NP-1:0] port_oe,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe
);
    for (genvar i = 0; i < NP; i++) begin : g_pad
        assign pad_out[i] = fsel[i] ? tmr_lvl[i] : port_lvl[i];
        assign pad_oe[i]  = fsel[i] ? 1'b1       : port_oe[i];
    end
endmodule

// File: rtl/cmt_pin_timer.sv
module cmt_pin_timer
    import cmt_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [1:0]    pad_out,
    output logic [1:0]    pad_oe,
    output logic [1:0]    tmr_lvl,
    output logic [CW-1:0] cnt_val
);
    chan_state_e     state_q;
    chan_state_e     state_d;
    logic            running;
    logic            pwm_q;
    logic [CW-1:0]   cmp_a_q;
    logic [CW-1:0]   cmp_b_q;
    logic [NPIN-1:0] fsel_q;
    logic [NPIN-1:0] port_lvl_q;
    logic [NPIN-1:0] port_oe_q;
    logic            hit_a;
    logic            hit_b;
    logic [NPIN-1:0] cfg_wr;
    logic [NPIN-1:0] cfg_keep;
    logic [NPIN-1:0] hit_init;
    logic [NPIN-1:0] hit_match;

    wire wr_ctrl = wr_en && (wr_addr == A_CTRL);

    // Controller next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (wr_ctrl &&  wr_data[0]) state_d = ST_COUNT;
            ST_COUNT: if (wr_ctrl && !wr_data[0]) state_d = ST_HALT;
        endcase
    end

    // Controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Controller outputs
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            ST_HALT:  running = 1'b0;
            ST_COUNT: running = 1'b1;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q      <= 1'b0;
            cmp_a_q    <= '1;
            cmp_b_q    <= '1;
            fsel_q     <= '0;
            port_lvl_q <= '0;
            port_oe_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  pwm_q <= wr_data[1];
                A_FSEL:  fsel_q <= wr_data[1:0];
                A_PORT: begin
                    port_lvl_q <= wr_data[1:0];
                    port_oe_q  <= wr_data[3:2];
                end
                A_CMP_A: cmp_a_q <= wr_data;
                A_CMP_B: cmp_b_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign hit_a = running && (cnt_val == cmp_a_q);
    assign hit_b = running && (cnt_val == cmp_b_q);

    cmt_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .clr      (hit_a && pwm_q),
        .load     (wr_en && (wr_addr == A_CNT)),
        .load_val (wr_data),
        .cnt      (cnt_val)
    );

    // Pin A: compare-A match in normal mode; period pin in pulse-width mode.
    // Pin B: duty pin; returns to its initial level on a period match.
    assign cfg_wr    = {wr_en && (wr_addr == A_CFG_B), wr_en && (wr_addr == A_CFG_A)};
    assign cfg_keep  = {1'b0, pwm_q};
    assign hit_init  = {hit_a && pwm_q, 1'b0};
    assign hit_match = {hit_b, hit_a && !pwm_q};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        cmt_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr[i]),
            .cfg_init  (wr_data[0]),
            .cfg_match (wr_data[1]),
            .cfg_keep  (cfg_keep[i]),
            .hit_init  (hit_init[i]),
            .hit_match (hit_match[i]),
            .lvl       (tmr_lvl[i])
        );
    end

    cmt_padmux #(.NP(NPIN)) u_mux (
        .fsel     (fsel_q),
        .tmr_lvl  (tmr_lvl),
        .port_lvl (port_lvl_q),
        .port_oe  (port_oe_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );
endmodule

// File: rtl/cmt_pin_timer_chk.sv
module cmt_pin_timer_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [1:0]    tmr_lvl,
    input logic [1:0]    pad_oe,
    input logic [CW-1:0] cnt_val,
    input logic          running,
    input logic          pwm,
    input logic [CW-1:0] cmp_a
);
    wire cnt_wr = wr_en && (wr_addr == 3'd7);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (tmr_lvl == 2'b00 && pad_oe == 2'b00 && cnt_val == '0)); // R1

    AST_CFG_B_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd2) |=> (tmr_lvl[1] == $past(wr_data[0]))); // R3

    AST_PWM_A_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && wr_en && wr_addr == 3'd1) |=> $stable(tmr_lvl[0])); // R4

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt_val)); // R5

    AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !pwm && !cnt_wr) |=> (cnt_val == $past(cnt_val) + CW'(1))); // R6

    AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pwm && cnt_val == cmp_a && !cnt_wr) |=> (cnt_val == '0)); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_val == $past(wr_data))); // R9
endmodule

bind cmt_pin_timer cmt_pin_timer_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tmr_lvl (tmr_lvl),
    .pad_oe  (pad_oe),
    .cnt_val (cnt_val),
    .running (running),
    .pwm     (pwm_q),
    .cmp_a   (cmp_a_q)
);

// File: tb/sim_cmt_pin_timer.sv
`timescale 1ns/1ps
module sim_cmt_pin_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pad_out, pad_oe, tmr_lvl;
    logic [15:0] cnt_val;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // expected-state model built from the requirements
    logic        m_run = 0, m_pwm = 0;
    logic [15:0] m_cnt = 0, m_ca = 16'hFFFF, m_cb = 16'hFFFF;
    logic [1:0]  m_lvl = 0, m_init = 0, m_match = 0, m_fsel = 0, m_plvl = 0, m_poe = 0;

    always #2.5 clk = ~clk;

    cmt_pin_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pad_out(pad_out), .pad_oe(pad_oe), .tmr_lvl(tmr_lvl),
        .cnt_val(cnt_val));

    task automatic chk(input string t, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [1:0] e_out, e_oe;
        for (int i = 0; i < 2; i++) begin
            e_out[i] = m_fsel[i] ? m_lvl[i] : m_plvl[i];
            e_oe[i]  = m_fsel[i] ? 1'b1 : m_poe[i];
        end
        chk(tag, "cnt_val", cnt_val, m_cnt);
        chk(tag, "tmr_lvl", {14'd0, tmr_lvl}, {14'd0, m_lvl});
        chk("R8", "pad_out", {14'd0, pad_out}, {14'd0, e_out});
        chk("R8", "pad_oe", {14'd0, pad_oe}, {14'd0, e_oe});
    endtask

    // advance one clock, update the model with the inputs seen at that edge
    task automatic tick();
        logic ha, hb, we;
        logic [15:0] n_cnt;
        logic [1:0]  n_lvl;
        @(posedge clk);
        we = wr_en;
        ha = m_run && (m_cnt == m_ca);
        hb = m_run && (m_cnt == m_cb);
        n_cnt = m_cnt;
        if (we && wr_addr == 3'd7) n_cnt = wr_data;
        else if (m_run) n_cnt = (ha && m_pwm) ? 16'd0 : m_cnt + 16'd1;
        n_lvl = m_lvl;
        if (we && wr_addr == 3'd1 && !m_pwm) n_lvl[0] = wr_data[0];
        else if (ha && !m_pwm) n_lvl[0] = m_match[0];
        if (we && wr_addr == 3'd2) n_lvl[1] = wr_data[0];
        else if (ha && m_pwm) n_lvl[1] = m_init[1];
        else if (hb) n_lvl[1] = m_match[1];
        if (we) begin
            case (wr_addr)
                3'd0: begin m_run = wr_data[0]; m_pwm = wr_data[1]; end
                3'd1: begin m_init[0] = wr_data[0]; m_match[0] = wr_data[1]; end
                3'd2: begin m_init[1] = wr_data[0]; m_match[1] = wr_data[1]; end
                3'd3: m_fsel = wr_data[1:0];
                3'd4: begin m_plvl = wr_data[1:0]; m_poe = wr_data[3:2]; end
                3'd5: m_ca = wr_data;
                3'd6: m_cb = wr_data;
                default: ;
            endcase
        end
        m_cnt = n_cnt;
        m_lvl = n_lvl;
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "tmr_lvl", {14'd0, tmr_lvl}, 16'd0);
        chk("R1", "pad_oe", {14'd0, pad_oe}, 16'd0);
        chk("R1", "cnt_val", cnt_val, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1"; idle(3);

        // R2/R3: pin control write loads initial level in normal mode
        tag = "R3";
        wr(3'd1, 16'h0001);
        chk("R3", "pin A init", {15'd0, tmr_lvl[0]}, 16'd1);
        wr(3'd2, 16'h0002);
        chk("R3", "pin B init", {15'd0, tmr_lvl[1]}, 16'd0);
        wr(3'd2, 16'h0001);

        // R8: port mode, enable, then timer mode (R2 map)
        tag = "R2";
        wr(3'd4, 16'h0009);
        chk("R8", "port pad_oe", {14'd0, pad_oe}, 16'd2);
        chk("R8", "port pad_out", {14'd0, pad_out}, 16'd1);
        wr(3'd3, 16'h0003);
        chk("R8", "timer pad_out", {14'd0, pad_out}, {14'd0, tmr_lvl});

        // R6: normal-mode sweep
        tag = "R6";
        for (int a = 1; a < 10; a += 3) begin
            for (int b = 0; b < 9; b += 2) begin
                wr(3'd0, 16'h0000);
                wr(3'd5, 16'(a));
                wr(3'd6, 16'(b));
                wr(3'd7, 16'd0);
                wr(3'd1, 16'h0002);
                wr(3'd2, 16'h0001);
                wr(3'd0, 16'h0001);
                idle(12);
            end
        end

        // R9 + R6: load near top while running, wrap
        tag = "R9";
        wr(3'd7, 16'hFFFD);
        chk("R9", "load", cnt_val, 16'hFFFD);
        tag = "R6";
        idle(5);

        // R5: stop freezes
        tag = "R5";
        wr(3'd0, 16'h0000);
        idle(6);
        chk("R5", "frozen cnt", cnt_val, m_cnt);

        // R7: pulse-width sweep, including duty 0, duty == period, duty > period
        tag = "R7";
        for (int p = 3; p < 7; p += 3) begin
            for (int d = 0; d <= p + 1; d++) begin
                wr(3'd0, 16'h0002);
                wr(3'd5, 16'(p));
                wr(3'd6, 16'(d));
                wr(3'd2, 16'h0001);
                tag = "R4";
                wr(3'd1, {15'd0, ~tmr_lvl[0]});
                tag = "R7";
                wr(3'd7, 16'd0);
                wr(3'd0, 16'h0003);
                idle(2 * (p + 1) + 3);
            end
        end

        // R9: counter write in the same cycle as a period match
        tag = "R9";
        wr(3'd7, 16'd6);
        wr(3'd7, 16'd2);
        chk("R9", "load over clear", cnt_val, 16'd2);
        idle(4);

        // R10: fault recovery from pulse-width to normal mode
        tag = "R10";
        wr(3'd4, {12'd0, 2'b11, ~tmr_lvl});
        wr(3'd3, 16'h0000);
        chk("R8", "forced inverse", {14'd0, pad_out}, {14'd0, m_plvl});
        wr(3'd0, 16'h0000);
        idle(2);
        wr(3'd5, 16'd4);
        wr(3'd6, 16'd2);
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'h0002);
        chk("R10", "pin A reinit", {15'd0, tmr_lvl[0]}, 16'd1);
        wr(3'd4, 16'h0000);
        chk("R8", "high-z", {14'd0, pad_oe}, 16'd0);
        wr(3'd7, 16'd0);
        wr(3'd3, 16'h0003);
        wr(3'd0, 16'h0001);
        idle(10);
        chk("R10", "no period clear", cnt_val, 16'd10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule